// File: doc/BRIEF.md
# Inbound DMA Address Translator

This block sits on the inbound side of a two-port PCIe bridge. Each request carries a 64-bit bus address issued by a downstream device and the number of the port it came in on. The block returns a 54-bit system address and a barrier attribute, or a translation fault. The bus address space is split into five windows. Two are direct windows. The 64-bit direct window passes the address through. The 32-bit direct window takes its upper system bits from a per-port register. The other three windows are paged and look up translation entries.

A 32-bit paged window and a 40-bit super-page window share one entry pool. The low part of that pool is set aside for super pages, with one slice per port. A second 40-bit window has its own entry table with a fixed 64 MB page. A single write port loads the entries, the per-port direct-map registers and the page-size code of the shared pool. A lookup is accepted on any cycle, and its result appears one cycle later.

Top module: `inbound_xlat`

## Requirements
- R1: A bus address with bit 63 set and bits 61:54 clear translates to a system address equal to bits 53:0, with the barrier output equal to bit 62.
- R2: A bus address with bit 63 set and any of bits 61:54 set (message-signalled or reserved) gives a fault.
- R3: Addresses 0x8000_0000 to 0xFFFF_FFFF translate to {direct-map register of the arriving port, address bits 29:0}, with the barrier equal to bit 30. A write with wr_tgt = 2 loads the register selected by wr_idx[0] from wr_data[23:0], which supplies system bits 53:30.
- R4: For addresses 0 to 0x7FFF_FFFF, bit 30 is the barrier and is left out of the offset. The offset is bits 29:0, and the index into the shared pool is that offset shifted right by 12 + 2*code. The code comes from wr_data[1:0] of a write with wr_tgt = 3, so codes 0 to 3 select 4 KB, 16 KB, 64 KB and 256 KB pages.
- R5: A 32-bit paged lookup whose index falls below the reserved count (64) or at or beyond the pool size (128) gives a fault.
- R6: Addresses 0x40_0000_0000 to 0x7F_FFFF_FFFF index the separate 40-bit table by (address - 0x40_0000_0000) >> 26, with a 64 MB page. An index at or beyond the table size (64) gives a fault, and the barrier is always 0.
- R7: Addresses 0x80_0000_0000 to 0xFF_FFFF_FFFF use 16 GB pages. The slice index is (address - 0x80_0000_0000) >> 34, and the pool entry used is port*32 + slice index. The barrier is always 0.
- R8: An entry (wr_tgt = 0 for the shared pool, 1 for the 40-bit table, at index wr_idx) is valid when wr_data bit 63 is set. The system address is entry bits 53:page-shift plus the address bits below the page shift, and entry bits below the page shift are ignored. A hit on an invalid entry gives a fault.
- R9: An address in none of the five windows gives a fault.
- R10: A fault drives out_fault high with out_addr zero and out_barrier zero.
- R11: out_valid rises exactly one cycle after in_valid, and it is low one cycle after a cycle with in_valid low.
- R12: A write becomes visible to lookups issued in the cycle after it. A lookup in the same cycle as a write sees the old contents.
- R13: After reset, out_valid is low, every entry is invalid, the direct-map registers are zero and the page-size code is 3 (256 KB).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Lookup request |
| in_port | input | 1 | Arriving port number |
| in_addr | input | 64 | Bus address to translate |
| wr_en | input | 1 | Configuration write strobe |
| wr_tgt | input | 2 | Write target: 0 shared entry, 1 40-bit entry, 2 direct map, 3 page size |
| wr_idx | input | 7 | Entry index, or port number for direct-map writes |
| wr_data | input | 64 | Write data |
| out_valid | output | 1 | Result valid |
| out_addr | output | 54 | Translated system address |
| out_barrier | output | 1 | Barrier attribute |
| out_fault | output | 1 | Translation fault |

## Verification
The bench probes the edges of each window. It uses the first and last entries a mode may reach and the first index beyond them. A design with an off-by-one limit would translate where it should fault. It checks that the same super-page offset faults or hits depending on the arriving port, so a design that ignores the per-port slice would return another port's page. It also sets bit 30 in the 32-bit paged window, which a design that failed to strip it would treat as a different index. Further directed tests change the page-size code and issue a lookup in the same cycle as the write of its entry. A design that decodes the shift wrongly, or that forwards write data, would return a different address for those lookups.

// File: rtl/xlat_pkg.sv
package xlat_pkg;
  typedef enum logic [2:0] {
    WIN_NONE,
    WIN_D64,
    WIN_D32,
    WIN_P32,
    WIN_P40,
    WIN_S40
  } win_e;

  typedef enum logic [1:0] {
    TGT_SHARED = 2'd0,
    TGT_WIDE   = 2'd1,
    TGT_DIRMAP = 2'd2,
    TGT_PGSZ   = 2'd3
  } wr_tgt_e;

  localparam int SYS_W       = 54;
  localparam int DIR_LSB     = 30;
  localparam int PG_BASE     = 12;
  localparam int WIDE_SHIFT  = 26;
  localparam int SUPER_SHIFT = 34;
endpackage

// File: rtl/xlat_win_decode.sv
module xlat_win_decode
  import xlat_pkg::*;
(
  input  logic [63:0] addr,
  output win_e        win
);
  always_comb begin
    if (addr[63]) begin
      win = (addr[61:54] == 8'd0) ? WIN_D64 : WIN_NONE;
    end else if (addr[62:40] != 23'd0) begin
      win = WIN_NONE;
    end else if (addr[39]) begin
      win = WIN_S40;
    end else if (addr[38]) begin
      win = WIN_P40;
    end else if (addr[37:32] != 6'd0) begin
      win = WIN_NONE;
    end else if (addr[31]) begin
      win = WIN_D32;
    end else begin
      win = WIN_P32;
    end
  end
endmodule

// File: rtl/xlat_entry_pool.sv
module xlat_entry_pool #(
  parameter int N    = 64,
  parameter int IW   = 6,
  parameter int SA_W = 54
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en,
  input  logic [IW-1:0]   wr_idx,
  input  logic [63:0]     wr_data,
  input  logic [IW-1:0]   rd_idx,
  output logic            rd_hit,
  output logic [SA_W-1:0] rd_page
);
  logic [N-1:0]    vld_q, vld_d;
  logic [SA_W-1:0] page_q [N];
  logic            wr_ok;

  assign wr_ok = wr_en && (int'(wr_idx) < N);

  always_comb begin
    vld_d = vld_q;
    if (wr_ok) vld_d[wr_idx] = wr_data[63];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) vld_q <= '0;
    else        vld_q <= vld_d;
  end

  always_ff @(posedge clk) begin
    if (wr_ok) page_q[wr_idx] <= wr_data[SA_W-1:0];
  end

  always_comb begin
    rd_hit  = 1'b0;
    rd_page = '0;
    if (int'(rd_idx) < N) begin
      rd_hit  = vld_q[rd_idx];
      rd_page = page_q[rd_idx];
    end
  end
endmodule

// File: rtl/inbound_xlat.sv
module inbound_xlat
  import xlat_pkg::*;
#(
  parameter int SHARED_N = 128,
  parameter int RSV_N    = 64,
  parameter int WIDE_N   = 64,
  parameter int PORTS    = 2,
  localparam int PORT_W  = (PORTS > 1) ? $clog2(PORTS) : 1,
  localparam int SH_IW   = $clog2(SHARED_N),
  localparam int WD_IW   = $clog2(WIDE_N),
  localparam int WI_W    = (SH_IW > WD_IW) ? SH_IW : WD_IW
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [PORT_W-1:0] in_port,
  input  logic [63:0]       in_addr,
  input  logic              wr_en,
  input  logic [1:0]        wr_tgt,
  input  logic [WI_W-1:0]   wr_idx,
  input  logic [63:0]       wr_data,
  output logic              out_valid,
  output logic [SYS_W-1:0]  out_addr,
  output logic              out_barrier,
  output logic              out_fault
);
  localparam int SLICE = RSV_N / PORTS;
  localparam int DM_W  = SYS_W - DIR_LSB;

  // configuration state
  logic [DM_W-1:0] dm_q [PORTS];
  logic [1:0]      pgsz_q;

  genvar gp;
  generate
    for (gp = 0; gp < PORTS; gp++) begin : g_dirmap
      logic dm_we;
      assign dm_we = wr_en && (wr_tgt == TGT_DIRMAP) && (int'(wr_idx) == gp);
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     dm_q[gp] <= '0;
        else if (dm_we) dm_q[gp] <= wr_data[DM_W-1:0];
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                             pgsz_q <= 2'd3;
    else if (wr_en && wr_tgt == TGT_PGSZ)   pgsz_q <= wr_data[1:0];
  end

  // window decode and index formation
  win_e win;
  xlat_win_decode u_dec (.addr(in_addr), .win(win));

  logic [4:0]       p32_shift;
  logic [29:0]      p32_raw;
  logic             p32_ok;
  logic [11:0]      wide_raw;
  logic             wide_ok;
  logic [4:0]       sup_raw;
  logic             sup_ok;
  logic [SH_IW-1:0] sh_rd;
  logic [WD_IW-1:0] wd_rd;

  always_comb begin
    p32_shift = 5'(PG_BASE) + {2'b00, pgsz_q, 1'b0};
    p32_raw   = in_addr[29:0] >> p32_shift;
    p32_ok    = (p32_raw >= 30'(RSV_N)) && (p32_raw < 30'(SHARED_N));
    wide_raw  = in_addr[37:26];
    wide_ok   = int'(wide_raw) < WIDE_N;
    sup_raw   = in_addr[38:34];
    sup_ok    = int'(sup_raw) < SLICE;
    wd_rd     = wide_raw[WD_IW-1:0];
    if (win == WIN_S40) sh_rd = SH_IW'(int'(in_port) * SLICE + int'(sup_raw));
    else                sh_rd = p32_raw[SH_IW-1:0];
  end

  // entry storage
  logic             sh_hit, wd_hit;
  logic [SYS_W-1:0] sh_page, wd_page;

  xlat_entry_pool #(.N(SHARED_N), .IW(SH_IW), .SA_W(SYS_W)) u_shared (
    .clk(clk), .rst_n(rst_n),
    .wr_en(wr_en && wr_tgt == TGT_SHARED), .wr_idx(wr_idx[SH_IW-1:0]),
    .wr_data(wr_data), .rd_idx(sh_rd), .rd_hit(sh_hit), .rd_page(sh_page)
  );

  xlat_entry_pool #(.N(WIDE_N), .IW(WD_IW), .SA_W(SYS_W)) u_wide (
    .clk(clk), .rst_n(rst_n),
    .wr_en(wr_en && wr_tgt == TGT_WIDE), .wr_idx(wr_idx[WD_IW-1:0]),
    .wr_data(wr_data), .rd_idx(wd_rd), .rd_hit(wd_hit), .rd_page(wd_page)
  );

  // result formation
  logic [5:0]       pg_shift;
  logic [SYS_W-1:0] pg_mask;
  logic [SYS_W-1:0] nxt_addr;
  logic             nxt_bar, nxt_fault;

  always_comb begin
    case (win)
      WIN_P40: pg_shift = 6'(WIDE_SHIFT);
      WIN_S40: pg_shift = 6'(SUPER_SHIFT);
      default: pg_shift = {1'b0, p32_shift};
    endcase
    pg_mask = (SYS_W'(1) << pg_shift) - SYS_W'(1);

    nxt_addr  = '0;
    nxt_bar   = 1'b0;
    nxt_fault = 1'b1;
    case (win)
      WIN_D64: begin
        nxt_addr  = in_addr[SYS_W-1:0];
        nxt_bar   = in_addr[62];
        nxt_fault = 1'b0;
      end
      WIN_D32: begin
        nxt_addr  = {dm_q[in_port], in_addr[DIR_LSB-1:0]};
        nxt_bar   = in_addr[30];
        nxt_fault = 1'b0;
      end
      WIN_P32: begin
        nxt_addr  = (sh_page & ~pg_mask) | (in_addr[SYS_W-1:0] & pg_mask);
        nxt_bar   = in_addr[30];
        nxt_fault = !(p32_ok && sh_hit);
      end
      WIN_P40: begin
        nxt_addr  = (wd_page & ~pg_mask) | (in_addr[SYS_W-1:0] & pg_mask);
        nxt_fault = !(wide_ok && wd_hit);
      end
      WIN_S40: begin
        nxt_addr  = (sh_page & ~pg_mask) | (in_addr[SYS_W-1:0] & pg_mask);
        nxt_fault = !(sup_ok && sh_hit);
      end
      default: nxt_fault = 1'b1;
    endcase
    if (nxt_fault) begin
      nxt_addr = '0;
      nxt_bar  = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) out_valid <= 1'b0;
    else        out_valid <= in_valid;
  end

  always_ff @(posedge clk) begin
    if (in_valid) begin
      out_addr    <= nxt_addr;
      out_barrier <= nxt_bar;
      out_fault   <= nxt_fault;
    end
  end

  // checks
  p_latency_r11: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);

  p_fault_clean_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_fault) |-> (out_addr == '0 && !out_barrier));

  p_direct_low_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_addr[63:31] == 33'd1) |=>
      (!out_fault && out_addr[29:0] == $past(in_addr[29:0]) && out_barrier == $past(in_addr[30])));

  p_wide_pass_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_addr[63] && in_addr[61:54] == 8'd0) |=>
      (!out_fault && out_addr == $past(in_addr[SYS_W-1:0]) && out_barrier == $past(in_addr[62])));

  p_no_barrier_40_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_addr[63:40] == 24'd0 && (in_addr[39] || in_addr[38])) |=> !out_barrier);
endmodule

// File: tb/sim_inbound_xlat.sv
module sim_inbound_xlat;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [0:0]  in_port = '0;
  logic [63:0] in_addr = '0;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_tgt = '0;
  logic [6:0]  wr_idx = '0;
  logic [63:0] wr_data = '0;
  logic        out_valid;
  logic [53:0] out_addr;
  logic        out_barrier;
  logic        out_fault;

  int n_chk = 0;
  int n_err = 0;
  bit done  = 1'b0;

  always #5 clk = ~clk;

  inbound_xlat u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_port(in_port), .in_addr(in_addr),
    .wr_en(wr_en), .wr_tgt(wr_tgt), .wr_idx(wr_idx), .wr_data(wr_data),
    .out_valid(out_valid), .out_addr(out_addr), .out_barrier(out_barrier), .out_fault(out_fault)
  );

  typedef struct packed {
    logic [7:0]  req;
    logic        port;
    logic [63:0] addr;
    logic        fault;
    logic        bar;
    logic [53:0] sys;
  } vec_t;

  localparam int NV = 21;
  localparam vec_t VECS [NV] = '{
    '{8'd1,  1'b0, 64'h8000_0012_3456_789A, 1'b0, 1'b0, 54'h12_3456_789A}, // R1
    '{8'd1,  1'b1, 64'hC000_0000_0000_1000, 1'b0, 1'b1, 54'h1000},         // R1 barrier
    '{8'd2,  1'b0, 64'h8040_0000_0000_0000, 1'b1, 1'b0, 54'h0},            // R2 reserved bit
    '{8'd2,  1'b0, 64'hA000_0000_0000_0000, 1'b1, 1'b0, 54'h0},            // R2 message bit
    '{8'd3,  1'b0, 64'h0000_0000_8123_4567, 1'b0, 1'b0, 54'h1_4123_4567},  // R3 port 0
    '{8'd3,  1'b1, 64'h0000_0000_C000_0010, 1'b0, 1'b1, 54'h2_8000_0010},  // R3 port 1
    '{8'd4,  1'b0, 64'h0000_0000_0103_ABCD, 1'b0, 1'b0, 54'h12_3403_ABCD}, // R4 first usable
    '{8'd4,  1'b1, 64'h0000_0000_4103_ABCD, 1'b0, 1'b1, 54'h12_3403_ABCD}, // R4 bit 30 stripped
    '{8'd8,  1'b0, 64'h0000_0000_0104_0000, 1'b1, 1'b0, 54'h0},            // R8 invalid entry
    '{8'd5,  1'b0, 64'h0000_0000_00FC_0000, 1'b1, 1'b0, 54'h0},            // R5 reserved index
    '{8'd8,  1'b0, 64'h0000_0000_01FF_FFFF, 1'b0, 1'b0, 54'h3_0003_FFFF},  // R8 low bits ignored
    '{8'd5,  1'b0, 64'h0000_0000_0200_0000, 1'b1, 1'b0, 54'h0},            // R5 past pool
    '{8'd6,  1'b0, 64'h0000_0040_0812_3456, 1'b0, 1'b0, 54'hA_BC12_3456},  // R6
    '{8'd6,  1'b1, 64'h0000_0040_FFFF_FFFF, 1'b0, 1'b0, 54'h3FF_FFFF},     // R6 last entry
    '{8'd6,  1'b0, 64'h0000_0041_0000_0000, 1'b1, 1'b0, 54'h0},            // R6 past table
    '{8'd7,  1'b0, 64'h0000_008D_2345_6789, 1'b0, 1'b0, 54'h11_2345_6789}, // R7 port 0
    '{8'd7,  1'b1, 64'h0000_0084_0000_0010, 1'b0, 1'b0, 54'h20_0000_0010}, // R7 port 1
    '{8'd7,  1'b1, 64'h0000_008C_0000_0000, 1'b1, 1'b0, 54'h0},            // R7 port 1 slice
    '{8'd7,  1'b0, 64'h0000_0084_0000_0000, 1'b1, 1'b0, 54'h0},            // R7 port 0 slice
    '{8'd9,  1'b0, 64'h0000_0001_0000_0000, 1'b1, 1'b0, 54'h0},            // R9 hole low
    '{8'd9,  1'b0, 64'h0000_0100_0000_0000, 1'b1, 1'b0, 54'h0}             // R9 hole high
  };

  task automatic wr(input logic [1:0] tgt, input logic [6:0] idx, input logic [63:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_tgt = tgt; wr_idx = idx; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic check(input string tag, input logic ef, input logic eb, input logic [53:0] ea);
    n_chk++;
    if (out_valid !== 1'b1 || out_fault !== ef || out_barrier !== eb || out_addr !== ea) begin
      n_err++;
      $display("FAIL %s: got v=%0b f=%0b b=%0b a=%h exp v=1 f=%0b b=%0b a=%h",
               tag, out_valid, out_fault, out_barrier, out_addr, ef, eb, ea);
    end
  endtask

  task automatic look(input string tag, input logic p, input logic [63:0] a,
                      input logic ef, input logic eb, input logic [53:0] ea);
    @(negedge clk);
    in_valid = 1'b1; in_port = p; in_addr = a;
    @(negedge clk);
    in_valid = 1'b0;
    check(tag, ef, eb, ea);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL watchdog: got hung exp finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_err);
      $finish;
    end
  end

  initial begin : main
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R13 reset state
    n_chk++;
    if (out_valid !== 1'b0) begin
      n_err++; $display("FAIL R13: got out_valid=%0b exp 0", out_valid);
    end
    look("R13 entries invalid", 1'b0, 64'h0000_0040_0812_3456, 1'b1, 1'b0, 54'h0);
    look("R13 dirmap zero", 1'b1, 64'h0000_0000_8000_0040, 1'b0, 1'b0, 54'h40);
    // R11 valid drops after idle cycle
    @(negedge clk);
    n_chk++;
    if (out_valid !== 1'b0) begin
      n_err++; $display("FAIL R11: got out_valid=%0b exp 0", out_valid);
    end

    wr(2'd2, 7'd0, 64'h5);
    wr(2'd2, 7'd1, 64'hA);
    wr(2'd0, 7'd64,  64'h8000_0012_3400_0000);
    wr(2'd0, 7'd127, 64'h8000_0003_0000_0123);
    wr(2'd0, 7'd3,   64'h8000_0010_0000_0000);
    wr(2'd0, 7'd33,  64'h8000_0020_0000_0000);
    wr(2'd1, 7'd2,   64'h8000_000A_BC00_0000);
    wr(2'd1, 7'd63,  64'h8000_0000_0000_0000);

    for (int i = 0; i < NV; i++) begin
      string t;
      t = $sformatf("R%0d vector %0d", VECS[i].req, i);
      look(t, VECS[i].port, VECS[i].addr, VECS[i].fault, VECS[i].bar, VECS[i].sys);
    end

    // R12 lookup in the same cycle as the write of its entry
    @(negedge clk);
    wr_en = 1'b1; wr_tgt = 2'd0; wr_idx = 7'd65; wr_data = 64'h8000_0007_0000_0000;
    in_valid = 1'b1; in_port = 1'b0; in_addr = 64'h0000_0000_0104_0000;
    @(negedge clk);
    wr_en = 1'b0; in_valid = 1'b0;
    check("R12 same cycle old", 1'b1, 1'b0, 54'h0);
    look("R12 next cycle new", 1'b0, 64'h0000_0000_0104_0010, 1'b0, 1'b0, 54'h7_0000_0010);

    // R4 page-size change to 4 KB
    wr(2'd3, 7'd0, 64'h0);
    look("R4 4KB page", 1'b0, 64'h0000_0000_0004_0123, 1'b0, 1'b0, 54'h12_3400_0123);
    look("R5 4KB reserved", 1'b0, 64'h0000_0000_0003_F000, 1'b1, 1'b0, 54'h0);
    // R8 invalidate an entry with bit 63 clear
    wr(2'd1, 7'd2, 64'h0000_000A_BC00_0000);
    look("R8 invalidated", 1'b0, 64'h0000_0040_0812_3456, 1'b1, 1'b0, 54'h0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_err);
    $finish;
  end
endmodule